// File: doc/BRIEF.md
# Shared GPIO Port with Converter Channel Takeover

This block is an eight-pin general-purpose I/O port whose pins also serve as the inputs of an eight-channel analog converter. Each pin has a data latch bit and a direction bit. Both are written and read over a small register bus. A third register holds the converter channel selection: an enable bit and a pin index.

While the converter is enabled, it claims the indexed pin. That pin stops driving its pad and is treated as an input whatever its direction bit says. A port read returns 0 in that pin's bit position, and the pin's synchronized pad level is presented on the converter sample output. Every other pin keeps working as ordinary GPIO. Register writes aimed at the claimed pin are still stored. They reach the pad as soon as the converter releases the pin, either by moving to another index or by clearing the enable bit.

Top module: `gpio_chanmux_port`

## Requirements
- R1: After reset the data, direction and channel registers are all zero. Every pad_oe and pad_out bit is 0, and conv_active and conv_sample are 0.
- R2: A write with reg_we=1 stores reg_wdata into the register chosen by reg_addr: 0 is data, 1 is direction, 2 is channel. A read with reg_re=1 presents that register on reg_rdata one clock later. The channel register reads back as {enable, index} in bits 3 and 2:0, with the upper bits zero.
- R3: A pin that is not claimed and has direction bit 1 drives pad_oe=1 and pad_out equal to its data bit. A pin with pad_oe=0 has pad_out=0.
- R4: In a data-register read, a pin that is not claimed returns its data latch when its direction bit is 1. When its direction bit is 0 it returns its pad level, delayed through a two-stage synchronizer.
- R5: The converter is enabled when channel bit 3 is 1, and then claims the pin given by channel bits 2:0. The claimed pin has pad_oe=0 whatever its direction bit, and at most one pin is claimed at a time.
- R6: While a pin stays claimed, writes to the data or direction register leave its pad_oe and pad_out unchanged.
- R7: A data-register read returns 0 in the bit position of the claimed pin.
- R8: Data and direction bits written while a pin is claimed are stored. They take effect on its pads once the pin is released by a new index or by clearing the enable bit.
- R9: conv_active equals the enable bit. conv_sample is the synchronized pad level of the claimed pin, and 0 when the converter is off.
- R10: Reading the direction register returns the full stored value, including the bit of the claimed pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 direction, 2 channel |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| conv_active | output | 1 | Converter holds a pin |
| conv_sample | output | 1 | Synchronized level of the claimed pin |

## Verification
Several rules are checked by assertions on every cycle:
- the claimed pin never has its driver enabled, and no more than one pin is claimed;
- an undriven pad stays low, and a claimed pin's drive stays still across register writes;
- the data latch stores every write, and claimed-pin reads return zero;
- the converter sample is quiet while the converter is off.

Other behaviour can only be shown by the bench's scenarios. This covers the hand-back of stored values when a pin is released, the mix of latch and pad values in reads, the synchronizer delay, and the readback of all registers across moves of the channel index, including the end indices 0 and 7.

// File: rtl/gpio_chanmux_pkg.sv
package gpio_chanmux_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_CHAN = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_in;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_chanmux_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int IDX_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0] wr_data,
  output logic [NPINS-1:0] data_q,
  output logic [NPINS-1:0] dir_q,
  output logic             chan_en_q,
  output logic [IDX_W-1:0] chan_idx_q
);

  logic [NPINS-1:0] data_d;
  logic [NPINS-1:0] dir_d;
  logic             chan_en_d;
  logic [IDX_W-1:0] chan_idx_d;
  logic             data_ce;
  logic             dir_ce;
  logic             chan_ce;

  always_comb begin
    data_ce    = wr_en && (wr_addr == REG_DATA);
    dir_ce     = wr_en && (wr_addr == REG_DIR);
    chan_ce    = wr_en && (wr_addr == REG_CHAN);
    data_d     = data_ce ? wr_data : data_q;
    dir_d      = dir_ce  ? wr_data : dir_q;
    chan_en_d  = chan_ce ? wr_data[IDX_W]     : chan_en_q;
    chan_idx_d = chan_ce ? wr_data[IDX_W-1:0] : chan_idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q     <= '0;
      dir_q      <= '0;
      chan_en_q  <= 1'b0;
      chan_idx_q <= '0;
    end else begin
      data_q     <= data_d;
      dir_q      <= dir_d;
      chan_en_q  <= chan_en_d;
      chan_idx_q <= chan_idx_d;
    end
  end

  // R8
  data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_DATA) |=> (data_q == $past(wr_data)));

  // R2
  dir_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_DIR) |=> (dir_q == $past(wr_data)));

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice #(
  parameter int INDEX = 0,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_bit,
  input  logic             dir_bit,
  input  logic             pad_level,
  input  logic             chan_en,
  input  logic [IDX_W-1:0] chan_idx,
  output logic             taken,
  output logic             oe,
  output logic             out,
  output logic             rd_bit
);

  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(INDEX);

  always_comb begin
    taken  = chan_en && (chan_idx == MY_IDX);
    oe     = dir_bit && !taken;
    out    = oe && data_bit;
    if (taken) begin
      rd_bit = 1'b0;
    end else if (dir_bit) begin
      rd_bit = data_bit;
    end else begin
      rd_bit = pad_level;
    end
  end

  // R3
  idle_pad_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !out);

  // R6
  taken_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && $past(taken)) |-> ($stable(oe) && $stable(out)));

endmodule

// File: rtl/gpio_chanmux_port.sv
module gpio_chanmux_port
  import gpio_chanmux_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [7:0]       pad_in,
  output logic [7:0]       pad_out,
  output logic [7:0]       pad_oe,
  output logic             conv_active,
  output logic             conv_sample
);

  localparam int IDX_W = $clog2(NPINS);

  logic [NPINS-1:0] data_q;
  logic [NPINS-1:0] dir_q;
  logic             chan_en_q;
  logic [IDX_W-1:0] chan_idx_q;
  logic [NPINS-1:0] pad_sync;
  logic [NPINS-1:0] taken_vec;
  logic [NPINS-1:0] rd_vec;
  logic [NPINS-1:0] rdata_d;
  logic [NPINS-1:0] rdata_q;

  gpio_regbank #(.NPINS(NPINS), .IDX_W(IDX_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_we),
    .wr_addr    (reg_addr),
    .wr_data    (reg_wdata),
    .data_q     (data_q),
    .dir_q      (dir_q),
    .chan_en_q  (chan_en_q),
    .chan_idx_q (chan_idx_q)
  );

  gpio_pad_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pad_in),
    .d_out (pad_sync)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_slice #(.INDEX(p), .IDX_W(IDX_W)) i_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_bit  (data_q[p]),
      .dir_bit   (dir_q[p]),
      .pad_level (pad_sync[p]),
      .chan_en   (chan_en_q),
      .chan_idx  (chan_idx_q),
      .taken     (taken_vec[p]),
      .oe        (pad_oe[p]),
      .out       (pad_out[p]),
      .rd_bit    (rd_vec[p])
    );
  end

  always_comb begin
    unique case (reg_addr)
      REG_DATA: rdata_d = rd_vec;
      REG_DIR:  rdata_d = dir_q;
      REG_CHAN: rdata_d = NPINS'({chan_en_q, chan_idx_q});
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (reg_re) begin
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata   = rdata_q;
  assign conv_active = chan_en_q;
  assign conv_sample = chan_en_q && pad_sync[chan_idx_q];

  // R5
  sel_pin_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en_q |-> !pad_oe[chan_idx_q]);

  // R5
  single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(taken_vec));

  // R7
  sel_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == REG_DATA && chan_en_q) |=> !reg_rdata[$past(chan_idx_q)]);

  // R9
  conv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_active |-> !conv_sample);

endmodule

// File: tb/test_gpio_chanmux_port.sv
module test_gpio_chanmux_port;

  typedef struct {
    bit         is_read;
    logic [7:0] exp_rd;
    logic [7:0] exp_oe;
    logic [7:0] exp_out;
    logic [1:0] exp_conv;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_re = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic       conv_active;
  logic       conv_sample;

  int checks = 0;
  int bad = 0;
  item_t sb_q[$];

  logic [7:0] m_data = '0;
  logic [7:0] m_dir  = '0;
  logic       m_en   = 1'b0;
  logic [2:0] m_idx  = '0;

  always #5 clk = ~clk;

  gpio_chanmux_port i_gpio_chanmux_port (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .conv_active(conv_active), .conv_sample(conv_sample)
  );

  function automatic logic [7:0] claim_mask();
    return m_en ? (8'd1 << m_idx) : 8'd0;
  endfunction

  function automatic logic [7:0] exp_oe();
    return m_dir & ~claim_mask();
  endfunction

  function automatic logic [7:0] exp_data_rd();
    return ((m_data & m_dir) | (pad_in & ~m_dir)) & ~claim_mask();
  endfunction

  // monitor: compares after each posedge
  always begin
    @(posedge clk);
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (it.is_read) begin
        if (reg_rdata !== it.exp_rd) begin
          bad++;
          $display("FAIL %s rdata act=%h exp=%h", it.tag, reg_rdata, it.exp_rd);
        end
      end else if (pad_oe !== it.exp_oe || pad_out !== it.exp_out ||
                   {conv_active, conv_sample} !== it.exp_conv) begin
        bad++;
        $display("FAIL %s pins act oe=%h out=%h conv=%b exp oe=%h out=%h conv=%b",
                 it.tag, pad_oe, pad_out, {conv_active, conv_sample},
                 it.exp_oe, it.exp_out, it.exp_conv);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    case (a)
      2'd0: m_data = d;
      2'd1: m_dir  = d;
      2'd2: begin m_en = d[3]; m_idx = d[2:0]; end
      default: ;
    endcase
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    it.is_read = 1'b1; it.exp_rd = exp; it.exp_oe = '0; it.exp_out = '0;
    it.exp_conv = '0; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic pins(input string tag);
    item_t it;
    @(negedge clk);
    it.is_read = 1'b0; it.exp_rd = '0;
    it.exp_oe = exp_oe(); it.exp_out = exp_oe() & m_data;
    it.exp_conv = {m_en, m_en & pad_in[m_idx]}; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic set_pad(input logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    pins("R1");
    rd(2'd0, 8'h00, "R1");
    rd(2'd1, 8'h00, "R1");
    rd(2'd2, 8'h00, "R1");
    // R2 / R3 / R4 plain GPIO
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'hA5);
    pins("R3");
    rd(2'd1, 8'hF0, "R2");
    set_pad(8'h3C);
    rd(2'd0, exp_data_rd(), "R4");
    // R5 / R7 / R9 claim pin 6
    wr(2'd2, 8'h0E);
    pins("R5");
    rd(2'd2, 8'h0E, "R2");
    rd(2'd0, exp_data_rd(), "R7");
    set_pad(8'h7C);
    pins("R9");
    rd(2'd0, exp_data_rd(), "R7");
    // R6 / R10 writes while claimed
    wr(2'd1, 8'hFF);
    pins("R6");
    wr(2'd0, 8'hFF);
    pins("R6");
    rd(2'd1, 8'hFF, "R10");
    // R8 release by moving index to 2
    wr(2'd2, 8'h0A);
    pins("R8");
    rd(2'd0, exp_data_rd(), "R7");
    // R8 release by clearing enable
    wr(2'd2, 8'h02);
    pins("R8");
    rd(2'd2, 8'h02, "R2");
    // R4 all inputs
    wr(2'd1, 8'h00);
    set_pad(8'h5A);
    rd(2'd0, 8'h5A, "R4");
    pins("R4");
    // R9 end indices
    wr(2'd2, 8'h08);
    pins("R9");
    rd(2'd0, exp_data_rd(), "R7");
    wr(2'd2, 8'h0F);
    set_pad(8'h80);
    pins("R9");
    rd(2'd0, 8'h00, "R7");
    wr(2'd1, 8'hFF);
    pins("R5");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule